// File: doc/BRIEF.md
# Synthesizer Divider Bank

This block collects the frequency dividers of a two-loop frequency synthesizer. One oscillator clock drives a main reference divider (12-bit ratio) and an auxiliary reference divider (14-bit ratio). A fixed divide-by-4 stage and a fixed divide-by-25 stage follow the main reference divider. Each loop, transmit and receive, has a 2-bit select that picks which of these four reference pulse trains feeds its phase comparison. Two 16-bit channel dividers count feedback events from the transmit and receive oscillators. The feedback events arrive as single-cycle count enables in the oscillator clock domain.

Every programmable divider has an enable. A disabled divider sits in state `DIV_OFF`, with its count and output at zero. When its enable rises it moves to `DIV_RUN`, and when its enable falls it returns to `DIV_OFF`. Within `DIV_RUN`, each terminal count emits a one-cycle pulse and reloads the ratio. A newly written ratio therefore takes effect only after the next terminal count. Each channel loop has a power-save pin that is high while its divider is off. In test mode the power-save pins instead carry the divided channel pulses. The ratios and control bits come from registers that are already latched outside this block.

Top module: `syn_div_bank`

## Requirements
- R1: With select code 0, a loop's reference output pulses once every `ref_ratio` clock cycles while `ref_en` is high (12-bit ratio, legal 16..4095).
- R2: With select code 3, a loop's reference output pulses once every `aux_ratio` cycles while `aux_en` is high (14-bit ratio, legal 16..16383).
- R3: A channel divider emits one pulse per `N` feedback events, where `N` is `tx_ratio` or `rx_ratio` (16-bit, legal 16..65535). When feedback arrives every k-th cycle, the period is k·N cycles.
- R4: While `aux_en` is low the auxiliary divider is powered down, and select code 3 yields no pulses.
- R5: Every divider output pulse is one cycle wide. A ratio changed mid-period does not disturb the period in progress and applies from the following period.
- R6: Outside test mode, `tx_ps`/`rx_ps` is high from the cycle after the channel enable falls and low while the divider runs. A disabled channel divider never pulses.
- R7: With `test_mode` high, `tx_ps`/`rx_ps` equal `tx_div_pulse`/`rx_div_pulse` in every cycle.
- R8: Select codes are 0 = main reference, 1 = main divided by 4, 2 = main divided by 25, 3 = auxiliary. Codes 1 and 2 give periods of 4·`ref_ratio` and 25·`ref_ratio`.
- R9: Any programmed ratio below 16 divides by 16.
- R10: After reset with all enables low, every pulse output is low and both power-save pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Main reference divider enable |
| ref_ratio | input | 12 | Main reference ratio |
| aux_en | input | 1 | Auxiliary reference divider enable |
| aux_ratio | input | 14 | Auxiliary reference ratio |
| tx_en | input | 1 | Transmit channel divider enable |
| tx_ratio | input | 16 | Transmit channel ratio |
| tx_fb | input | 1 | Transmit feedback event, one cycle per event |
| rx_en | input | 1 | Receive channel divider enable |
| rx_ratio | input | 16 | Receive channel ratio |
| rx_fb | input | 1 | Receive feedback event, one cycle per event |
| tx_ref_sel | input | 2 | Transmit loop reference select |
| rx_ref_sel | input | 2 | Receive loop reference select |
| test_mode | input | 1 | Route divided channel pulses to power-save pins |
| tx_ref_pulse | output | 1 | Selected transmit reference pulse |
| rx_ref_pulse | output | 1 | Selected receive reference pulse |
| tx_div_pulse | output | 1 | Transmit channel divider pulse |
| rx_div_pulse | output | 1 | Receive channel divider pulse |
| tx_ps | output | 1 | Transmit power-save status or test output |
| rx_ps | output | 1 | Receive power-save status or test output |

## Verification
The assertions rely on the ratio clamp guaranteeing at least 16 events between channel pulses. They also assume that feedback strobes are single-cycle enables synchronous to `clk`. The aux-quiet and power-save properties assume that the select and test inputs hold steady across the cycle they inspect. The bench drives every input at the falling clock edge. It changes ratios only once a pulse has been seen, and it sweeps only small ratios plus one legal maximum, so every measured period lies within the window it waits for.

// File: rtl/syn_div_pkg.sv
package syn_div_pkg;
    localparam int MIN_RATIO = 16;

    typedef enum logic [1:0] {
        SEL_MAIN    = 2'd0,
        SEL_MAIN_Q  = 2'd1,
        SEL_MAIN_25 = 2'd2,
        SEL_AUX     = 2'd3
    } ref_sel_e;

    typedef enum logic {
        DIV_OFF = 1'b0,
        DIV_RUN = 1'b1
    } div_state_e;
endpackage

// File: rtl/syn_prog_div.sv
module syn_prog_div
    import syn_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse,
    output logic         running
);
    localparam logic [W-1:0] MIN_R = W'(MIN_RATIO);

    div_state_e   state_q, state_d;
    logic [W-1:0] cnt_q;
    logic [W-1:0] active_q;
    logic [W-1:0] ratio_clamped;

    assign ratio_clamped = (ratio < MIN_R) ? MIN_R : ratio;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_OFF: if (enable)  state_d = DIV_RUN;
            DIV_RUN: if (!enable) state_d = DIV_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIV_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= MIN_R;
            pulse    <= 1'b0;
        end else begin
            unique case (state_q)
                DIV_OFF: begin
                    cnt_q    <= '0;
                    pulse    <= 1'b0;
                    active_q <= ratio_clamped;
                end
                DIV_RUN: begin
                    if (!enable) begin
                        cnt_q <= '0;
                        pulse <= 1'b0;
                    end else if (tick) begin
                        if (cnt_q == active_q - W'(1)) begin
                            cnt_q    <= '0;
                            pulse    <= 1'b1;
                            active_q <= ratio_clamped;
                        end else begin
                            cnt_q <= cnt_q + W'(1);
                            pulse <= 1'b0;
                        end
                    end else begin
                        pulse <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign running = (state_q == DIV_RUN);
endmodule

// File: rtl/syn_fixed_div.sv
module syn_fixed_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic in_pulse,
    output logic out_pulse
);
    localparam int CW = $clog2(DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            out_pulse <= 1'b0;
        end else if (!active) begin
            cnt_q     <= '0;
            out_pulse <= 1'b0;
        end else if (in_pulse) begin
            if (cnt_q == LAST) begin
                cnt_q     <= '0;
                out_pulse <= 1'b1;
            end else begin
                cnt_q     <= cnt_q + CW'(1);
                out_pulse <= 1'b0;
            end
        end else begin
            out_pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/syn_ref_route.sv
module syn_ref_route
    import syn_div_pkg::*;
(
    input  ref_sel_e sel,
    input  logic     main_p,
    input  logic     quarter_p,
    input  logic     slow_p,
    input  logic     aux_p,
    output logic     ref_p
);
    always_comb begin
        unique case (sel)
            SEL_MAIN:    ref_p = main_p;
            SEL_MAIN_Q:  ref_p = quarter_p;
            SEL_MAIN_25: ref_p = slow_p;
            SEL_AUX:     ref_p = aux_p;
        endcase
    end
endmodule

// File: rtl/syn_div_bank.sv
module syn_div_bank
    import syn_div_pkg::*;
#(
    parameter int REF_W  = 12,
    parameter int AUX_W  = 14,
    parameter int CH_W   = 16,
    parameter int Q_DIV  = 4,
    parameter int S_DIV  = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic [REF_W-1:0] ref_ratio,
    input  logic             aux_en,
    input  logic [AUX_W-1:0] aux_ratio,
    input  logic             tx_en,
    input  logic [CH_W-1:0]  tx_ratio,
    input  logic             tx_fb,
    input  logic             rx_en,
    input  logic [CH_W-1:0]  rx_ratio,
    input  logic             rx_fb,
    input  logic [1:0]       tx_ref_sel,
    input  logic [1:0]       rx_ref_sel,
    input  logic             test_mode,
    output logic             tx_ref_pulse,
    output logic             rx_ref_pulse,
    output logic             tx_div_pulse,
    output logic             rx_div_pulse,
    output logic             tx_ps,
    output logic             rx_ps
);
    localparam int NLOOP = 2;

    logic main_p, main_run, quarter_p, slow_p, aux_p, aux_run;

    syn_prog_div #(.W(REF_W)) u_main (
        .clk(clk), .rst_n(rst_n), .enable(ref_en), .tick(1'b1),
        .ratio(ref_ratio), .pulse(main_p), .running(main_run)
    );

    syn_prog_div #(.W(AUX_W)) u_aux (
        .clk(clk), .rst_n(rst_n), .enable(aux_en), .tick(1'b1),
        .ratio(aux_ratio), .pulse(aux_p), .running(aux_run)
    );

    syn_fixed_div #(.DIV(Q_DIV)) u_quarter (
        .clk(clk), .rst_n(rst_n), .active(main_run),
        .in_pulse(main_p), .out_pulse(quarter_p)
    );

    syn_fixed_div #(.DIV(S_DIV)) u_slow (
        .clk(clk), .rst_n(rst_n), .active(main_run),
        .in_pulse(main_p), .out_pulse(slow_p)
    );

    logic [CH_W-1:0] ch_ratio [NLOOP];
    logic            ch_en    [NLOOP];
    logic            ch_fb    [NLOOP];
    logic [1:0]      ch_sel   [NLOOP];
    logic            ch_pulse [NLOOP];
    logic            ch_run   [NLOOP];
    logic            ch_ref   [NLOOP];
    logic            ch_ps    [NLOOP];

    assign ch_ratio[0] = tx_ratio;
    assign ch_ratio[1] = rx_ratio;
    assign ch_en[0]    = tx_en;
    assign ch_en[1]    = rx_en;
    assign ch_fb[0]    = tx_fb;
    assign ch_fb[1]    = rx_fb;
    assign ch_sel[0]   = tx_ref_sel;
    assign ch_sel[1]   = rx_ref_sel;

    for (genvar g = 0; g < NLOOP; g++) begin : g_loop
        syn_prog_div #(.W(CH_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .enable(ch_en[g]), .tick(ch_fb[g]),
            .ratio(ch_ratio[g]), .pulse(ch_pulse[g]), .running(ch_run[g])
        );

        syn_ref_route u_route (
            .sel(ref_sel_e'(ch_sel[g])), .main_p(main_p),
            .quarter_p(quarter_p), .slow_p(slow_p), .aux_p(aux_p),
            .ref_p(ch_ref[g])
        );

        assign ch_ps[g] = test_mode ? ch_pulse[g] : !ch_run[g];
    end

    assign tx_ref_pulse = ch_ref[0];
    assign rx_ref_pulse = ch_ref[1];
    assign tx_div_pulse = ch_pulse[0];
    assign rx_div_pulse = ch_pulse[1];
    assign tx_ps        = ch_ps[0];
    assign rx_ps        = ch_ps[1];
endmodule

// File: rtl/syn_div_bank_chk.sv
module syn_div_bank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       aux_en,
    input logic       tx_en,
    input logic       rx_en,
    input logic [1:0] rx_ref_sel,
    input logic       test_mode,
    input logic       rx_ref_pulse,
    input logic       tx_div_pulse,
    input logic       rx_div_pulse,
    input logic       tx_ps,
    input logic       rx_ps
);
    logic [4:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            gap_q <= 5'd16;
        else if (tx_div_pulse) gap_q <= 5'd0;
        else if (gap_q != 5'd16) gap_q <= gap_q + 5'd1;
    end

    p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_div_pulse |=> !tx_div_pulse);

    p_min_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_div_pulse |-> (gap_q >= 5'd15));

    p_ps_high_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rx_en) && !test_mode) |-> rx_ps);

    p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!tx_en) |-> !tx_div_pulse);

    p_aux_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!aux_en) && rx_ref_sel == 2'd3) |-> !rx_ref_pulse);

    p_test_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (tx_ps == tx_div_pulse));
endmodule

bind syn_div_bank syn_div_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .aux_en(aux_en), .tx_en(tx_en), .rx_en(rx_en),
    .rx_ref_sel(rx_ref_sel), .test_mode(test_mode), .rx_ref_pulse(rx_ref_pulse),
    .tx_div_pulse(tx_div_pulse), .rx_div_pulse(rx_div_pulse),
    .tx_ps(tx_ps), .rx_ps(rx_ps)
);

// File: tb/sim_syn_div_bank.sv
`timescale 1ns/1ps
module sim_syn_div_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b0, aux_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic [11:0] ref_ratio = 12'd16;
    logic [13:0] aux_ratio = 14'd16;
    logic [15:0] tx_ratio = 16'd16, rx_ratio = 16'd16;
    logic        tx_fb = 1'b0, rx_fb = 1'b0;
    logic [1:0]  tx_ref_sel = 2'd0, rx_ref_sel = 2'd0;
    logic        test_mode = 1'b0;
    logic        tx_ref_pulse, rx_ref_pulse, tx_div_pulse, rx_div_pulse, tx_ps, rx_ps;

    int n_chk = 0;
    int n_bad = 0;
    int tx_gap = 1;
    int rx_gap = 1;
    int cyc = 0;

    always #2.5 clk = ~clk;

    syn_div_bank u0 (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .ref_ratio(ref_ratio),
        .aux_en(aux_en), .aux_ratio(aux_ratio), .tx_en(tx_en), .tx_ratio(tx_ratio),
        .tx_fb(tx_fb), .rx_en(rx_en), .rx_ratio(rx_ratio), .rx_fb(rx_fb),
        .tx_ref_sel(tx_ref_sel), .rx_ref_sel(rx_ref_sel), .test_mode(test_mode),
        .tx_ref_pulse(tx_ref_pulse), .rx_ref_pulse(rx_ref_pulse),
        .tx_div_pulse(tx_div_pulse), .rx_div_pulse(rx_div_pulse),
        .tx_ps(tx_ps), .rx_ps(rx_ps)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tx_fb = (cyc % tx_gap) == 0;
            rx_fb = (cyc % rx_gap) == 0;
            if (cyc > 190000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: act %0d expected below 190000", cyc);
                summary();
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int idx);
        case (idx)
            0: return tx_ref_pulse;
            1: return rx_ref_pulse;
            2: return tx_div_pulse;
            default: return rx_div_pulse;
        endcase
    endfunction

    task automatic wait_pulse(input int idx, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sig(idx) && n < 20000);
    endtask

    task automatic period(input int idx, output int p);
        int dummy;
        wait_pulse(idx, dummy);
        wait_pulse(idx, p);
    endtask

    task automatic quiet(input int idx, input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sig(idx)) seen++;
        end
    endtask

    initial begin
        int p, s;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 tx_ps", int'(tx_ps), 1);
        chk("R10 rx_ps", int'(rx_ps), 1);
        chk("R10 pulses", int'(tx_ref_pulse | rx_ref_pulse | tx_div_pulse | rx_div_pulse), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 ps after reset", int'(tx_ps & rx_ps), 1);

        // R1 main reference sweep
        ref_en = 1'b1;
        for (int r = 16; r <= 24; r++) begin
            ref_ratio = 12'(r);
            period(0, p);
            chk("R1 main period", p, r);
        end
        ref_ratio = 12'd4095;
        period(0, p);
        chk("R1 main max", p, 4095);

        // R9 clamp below minimum
        for (int r = 0; r < 16; r++) begin
            ref_ratio = 12'(r);
            period(0, p);
            chk("R9 clamp", p, 16);
        end

        // R8 select codes with main ratio 16
        ref_ratio = 12'd16;
        aux_en = 1'b1; aux_ratio = 14'd37;
        tx_ref_sel = 2'd1; period(0, p); chk("R8 sel1", p, 64);
        tx_ref_sel = 2'd2; period(0, p); chk("R8 sel2", p, 400);
        tx_ref_sel = 2'd3; period(0, p); chk("R8 sel3", p, 37);
        tx_ref_sel = 2'd0; period(0, p); chk("R8 sel0", p, 16);

        // R2 auxiliary sweep via receive loop
        rx_ref_sel = 2'd3;
        for (int r = 16; r <= 20; r++) begin
            aux_ratio = 14'(r);
            period(1, p);
            chk("R2 aux period", p, r);
        end
        aux_ratio = 14'd1000;
        period(1, p); chk("R2 aux 1000", p, 1000);

        // R4 aux powered down
        aux_en = 1'b0;
        @(negedge clk);
        quiet(1, 1200, s);
        chk("R4 aux quiet", s, 0);

        // R3 channel dividers
        tx_en = 1'b1; rx_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 tx_ps running", int'(tx_ps), 0);
        chk("R6 rx_ps running", int'(rx_ps), 0);
        for (int n = 16; n <= 22; n++) begin
            tx_ratio = 16'(n);
            period(2, p);
            chk("R3 tx period", p, n);
        end
        rx_gap = 2;
        for (int n = 17; n <= 21; n++) begin
            rx_ratio = 16'(n);
            period(3, p);
            chk("R3 rx period gap2", p, 2 * n);
        end
        tx_gap = 3;
        tx_ratio = 16'd20;
        period(2, p); chk("R3 tx period gap3", p, 60);
        tx_gap = 1;
        rx_ratio = 16'd5;
        period(3, p); chk("R9 rx clamp", p, 32);

        // R5 ratio change takes effect one period later
        period(2, p);
        tx_ratio = 16'd30;
        wait_pulse(2, p); chk("R5 current period kept", p, 20);
        wait_pulse(2, p); chk("R5 new period", p, 30);
        // R5 pulse width
        @(negedge clk);
        chk("R5 single cycle", int'(tx_div_pulse), 0);

        // R6 power down
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 tx_ps off", int'(tx_ps), 1);
        quiet(2, 100, s);
        chk("R6 tx silent", s, 0);

        // R7 test mode
        tx_en = 1'b1; test_mode = 1'b1;
        begin
            int mism = 0;
            int cnt = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (tx_ps != tx_div_pulse) mism++;
                if (rx_ps != rx_div_pulse) mism++;
                if (tx_ps) cnt++;
            end
            chk("R7 mirror mismatches", mism, 0);
            chk("R7 tx_ps pulses", int'(cnt >= 5), 1);
        end
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 rx_ps off in test", int'(rx_ps), 0);
        test_mode = 1'b0;
        @(negedge clk);
        chk("R6 rx_ps off after test", int'(rx_ps), 1);

        summary();
    end
endmodule